// File: doc/BRIEF.md
# Carry-Free Adder Result Checker

This block sits beside an existing n-bit two's complement adder/subtractor and raises an error flag when the adder's result is wrong. It does not contain a second adder. It takes the two operands, the adder's result and the add/subtract control, and it checks one identity without any carry propagation. The identity is that the first operand, plus the conditioned second operand, plus the bitwise complement of the result, plus the subtract bit, gives all ones modulo 2^n.

A row of 3:2 full-adder cells reduces the three vectors to a sum vector and a carry vector. The carry vector moves up one place, and the subtract bit fills the empty low position. The result is correct exactly when the sum vector and the moved carry vector are bitwise complements. Any position where the two bits agree is a mismatch, and the mismatches are OR-reduced to the flag. The adder under test stays outside the block.

An optional output register adds one cycle of latency. The flag logic is exact: it flags every result that differs from the true sum or difference modulo 2^n, and never flags a correct one.

Top module: `sum_guard`

## Requirements
- R1: With sub_i=0, err_o is 0 whenever s_i equals (x_i + y_i) mod 2^WIDTH.
- R2: With sub_i=1, err_o is 0 whenever s_i equals (x_i - y_i) mod 2^WIDTH.
- R3: Flipping any single bit of a correct s_i drives err_o to 1.
- R4: The carry out of the top bit is discarded, so a correct result that wraps past 2^WIDTH (or below zero when subtracting) gives err_o=0.
- R5: With REG_OUT=0, err_o is a combinational function of the current x_i, y_i, s_i and sub_i, with no clock edge needed.
- R6: With REG_OUT=1, err_o shows the verdict for the inputs sampled at the previous rising edge of clk_i. It holds steady between edges and reads 0 while rst_ni is low.
- R7: For every s_i that differs from the correct result (any number of wrong bits), err_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| x_i | input | WIDTH | First operand given to the adder under test |
| y_i | input | WIDTH | Second operand given to the adder under test |
| s_i | input | WIDTH | Result produced by the adder under test |
| sub_i | input | 1 | 1 when the adder computed x_i - y_i, 0 when it computed x_i + y_i |
| err_o | output | 1 | 1 when s_i is not the correct result |

## Verification
The hardest cases are errors that carry-save logic could mask: a wrong result whose error sits only in the subtract-filled low position, or a correct result that wraps through the top bit. Random operands reach these cases too rarely. The bench therefore sweeps every operand, result and mode combination of a 4-bit instance, so every wrap and every low-position error appears. On a 32-bit registered instance it then flips each bit of correct results in turn, including results placed at the wrap boundaries.

// File: rtl/sum_guard_pkg.sv
package sum_guard_pkg;
  // majority of three: carry of a full-adder cell
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (c & (a ^ b));
  endfunction
endpackage

// File: rtl/operand_cond.sv
module operand_cond #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] y_i,
  input  logic [WIDTH-1:0] s_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] yc_o,
  output logic [WIDTH-1:0] sn_o
);
  assign yc_o = y_i ^ {WIDTH{sub_i}};
  assign sn_o = ~s_i;
endmodule

// File: rtl/csa_row.sv
module csa_row #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] c_i,
  output logic [WIDTH-1:0] sv_o,
  output logic [WIDTH-2:0] cv_o
);
  import sum_guard_pkg::*;
  for (genvar k = 0; k < WIDTH; k++) begin : g_cell
    assign sv_o[k] = a_i[k] ^ b_i[k] ^ c_i[k];
    // top carry would leave the word: never built
    if (k < WIDTH - 1) begin : g_cy
      assign cv_o[k] = maj3(a_i[k], b_i[k], c_i[k]);
    end
  end
endmodule

// File: rtl/vec_match.sv
module vec_match #(
  parameter int WIDTH = 32,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] sv_i,
  input  logic [WIDTH-2:0] cv_i,
  input  logic             sub_i,
  output logic             err_o
);
  localparam int NGRP = (WIDTH + GROUP - 1) / GROUP;
  localparam int PADW = NGRP * GROUP;

  logic [WIDTH-1:0] h;
  logic [PADW-1:0]  miss;
  logic [NGRP-1:0]  grp_miss;

  assign h = {cv_i, sub_i};

  // agreeing bits mean the pair is not complementary
  for (genvar k = 0; k < PADW; k++) begin : g_miss
    if (k < WIDTH) begin : g_real
      assign miss[k] = ~(sv_i[k] ^ h[k]);
    end else begin : g_pad
      assign miss[k] = 1'b0;
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_or
    assign grp_miss[g] = |miss[g*GROUP +: GROUP];
  end

  assign err_o = |grp_miss;
endmodule

// File: rtl/sum_guard.sv
module sum_guard #(
  parameter int WIDTH   = 32,
  parameter bit REG_OUT = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic [WIDTH-1:0] s_i,
  input  logic             sub_i,
  output logic             err_o
);
  logic [WIDTH-1:0] yc, sn, sv;
  logic [WIDTH-2:0] cv;
  logic             err_now;

  operand_cond #(.WIDTH(WIDTH)) u_cond (
    .y_i(y_i), .s_i(s_i), .sub_i(sub_i), .yc_o(yc), .sn_o(sn)
  );

  csa_row #(.WIDTH(WIDTH)) u_csa (
    .a_i(x_i), .b_i(yc), .c_i(sn), .sv_o(sv), .cv_o(cv)
  );

  vec_match #(.WIDTH(WIDTH)) u_match (
    .sv_i(sv), .cv_i(cv), .sub_i(sub_i), .err_o(err_now)
  );

  if (REG_OUT) begin : g_reg
    logic err_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) err_q <= 1'b0;
      else         err_q <= err_now;
    end
    assign err_o = err_q;
  end else begin : g_comb
    assign err_o = err_now;
  end

  // arithmetic reference for the checks below
  logic [WIDTH-1:0] ref_sum, wrap_lhs, wrap_rhs;
  assign ref_sum  = x_i + (sub_i ? ~y_i : y_i) + {{(WIDTH-1){1'b0}}, sub_i};
  assign wrap_lhs = sv + {cv, 1'b0};
  assign wrap_rhs = x_i + yc + sn;

  // R1
  add_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sub_i && s_i == ref_sum) |-> !err_now);
  // R2
  sub_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_i && s_i == ref_sum) |-> !err_now);
  // R3
  single_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(s_i ^ ref_sum) == 1) |-> err_now);
  // R4
  csa_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_lhs == wrap_rhs);
  // R7
  any_wrong_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_i != ref_sum) |-> err_now);

  if (REG_OUT) begin : g_reg_chk
    // R6
    reg_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (err_o == $past(s_i != ref_sum)));
  end
endmodule

// File: tb/sim_sum_guard.sv
`timescale 1ns/1ps
module sim_sum_guard;
  localparam int NS = 4;
  localparam int NL = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NS-1:0] xs = '0, ys = '0, ss = '0;
  logic          subs = 1'b0;
  logic          errs;
  logic [NL-1:0] xl = '0, yl = '0, sl = '0;
  logic          subl = 1'b0;
  logic          errl;

  int checks = 0;
  int fails  = 0;

  sum_guard #(.WIDTH(NS), .REG_OUT(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .x_i(xs), .y_i(ys), .s_i(ss),
    .sub_i(subs), .err_o(errs)
  );

  sum_guard #(.WIDTH(NL), .REG_OUT(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .x_i(xl), .y_i(yl), .s_i(sl),
    .sub_i(subl), .err_o(errl)
  );

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0b exp=%0b", req, got, exp);
    end
  endtask

  function automatic logic [NL-1:0] good_l(input logic [NL-1:0] a,
                                           input logic [NL-1:0] b, input logic s);
    return s ? a - b : a + b;
  endfunction

  // drive u1 at negedge, verdict appears after the next posedge
  task automatic run_l(input logic [NL-1:0] a, input logic [NL-1:0] b,
                       input logic s, input logic [NL-1:0] r, input string req);
    logic exp;
    @(negedge clk);
    xl = a; yl = b; subl = s; sl = r;
    exp = (r != good_l(a, b, s));
    @(posedge clk);
    #1;
    check(errl, exp, req);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, fails);
    $finish;
  end

  initial begin
    logic [NL-1:0] a, b, r;
    // R6: reset holds the registered flag low despite a wrong result
    xl = 32'd5; yl = 32'd7; sl = 32'd99; subl = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(errl, 1'b0, "R6 reset");
    @(negedge clk);
    rst_n = 1'b1;

    // exhaustive 4-bit sweep on the combinational instance
    for (int sb = 0; sb < 2; sb++) begin
      for (int xv = 0; xv < 16; xv++) begin
        for (int yv = 0; yv < 16; yv++) begin
          for (int sv = 0; sv < 16; sv++) begin
            int full, good;
            logic exp;
            string req;
            xs = NS'(xv); ys = NS'(yv); ss = NS'(sv); subs = sb[0];
            full = sb ? (xv - yv) : (xv + yv);
            good = full & 15;
            exp  = (sv != good);
            if (exp) begin
              req = ($countones(NS'(sv ^ good)) == 1) ? "R3" : "R7";
            end else if (full < 0 || full > 15) begin
              req = "R4";
            end else begin
              req = sb ? "R2" : "R1";
            end
            #1;
            check(errs, exp, req);
          end
        end
      end
    end

    // R5: the unregistered flag follows s with no clock edge
    @(negedge clk);
    xs = 4'd3; ys = 4'd4; subs = 1'b0; ss = 4'd7;
    #1 check(errs, 1'b0, "R5 pass");
    ss = 4'd6;
    #1 check(errs, 1'b1, "R5 same-cycle flag");

    // R6: registered flag holds between edges
    run_l(32'd10, 32'd20, 1'b0, 32'd30, "R6 pass");
    @(negedge clk);
    sl = 32'd31;
    #1 check(errl, 1'b0, "R6 hold until edge");
    @(posedge clk);
    #1 check(errl, 1'b1, "R6 flag after edge");

    // R4 wrap on the wide instance
    run_l(32'hFFFF_FFFF, 32'd1, 1'b0, 32'd0, "R4 add wrap");
    run_l(32'd0, 32'd1, 1'b1, 32'hFFFF_FFFF, "R4 sub wrap");
    run_l(32'h8000_0000, 32'h8000_0000, 1'b0, 32'd0, "R4 top carry");

    // R3: flip every bit of correct results, random and boundary operands
    for (int t = 0; t < 12; t++) begin
      logic s;
      s = t[0];
      if (t < 2) begin
        a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF;
      end else if (t < 4) begin
        a = 32'd0; b = 32'd0;
      end else begin
        a = $urandom; b = $urandom;
      end
      r = good_l(a, b, s);
      run_l(a, b, s, r, s ? "R2 wide" : "R1 wide");
      for (int k = 0; k < NL; k++) begin
        run_l(a, b, s, r ^ (32'd1 << k), "R3 flip");
      end
      run_l(a, b, s, r + 32'd1, "R7 off by one");
      run_l(a, b, s, ~r, "R7 inverted");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, fails);
    $finish;
  end
endmodule